// File: doc/BRIEF.md
# Floating-Point Unit Self-Test Sequencer

This block drives a fixed diagnostic program into an external floating-point datapath and counts how many results disagree with their known answers. The datapath is reached over a 16-bit bus. For each test vector the sequencer loads the B operand as two halves and then the A operand as two halves, issuing an operation code with the first A half. It then waits a fixed number of idle cycles and unloads the 32-bit result, upper half first. It also samples a 4-bit status port and judges all of these against constants built into the program.

The program covers add, subtract, multiply, integer-to-float conversion, absolute difference and an add of two invalid operands. Operand patterns are alternating-bit words and the constant 1.0, so every data line toggles both ways. A pass ends with a one-cycle completion strobe. At that moment the fault count holds the result of the pass, and zero means the datapath is healthy. The count is then cleared and the program starts again at once.

Top module: `fpu_selftest`

## Requirements
- R1: While reset is held, and after it, the fault count reads zero, the completion strobe and the unload strobe are low, and the operation code is 0.
- R2: Each vector makes exactly four bus writes on consecutive cycles: B upper, B lower (select 0), then A upper, A lower (select 1). A nonzero operation code appears only on the A-upper write. Codes: 1 add, 2 subtract A-B, 3 multiply, 4 convert the low 24 bits of A to float, 5 absolute difference |A-B|.
- R3: After the A-lower write the bus stays idle for exactly WAIT_CYC cycles. An upper-half unload (select 1) and a lower-half unload (select 0) follow on consecutive cycles. Read data is taken one cycle after each unload strobe.
- R4: Vectors run in this order. Four adds: AAAAAAAA+0, 55555555+0, 0+55555555, 0+AAAAAAAA. One subtract: 55555555-55555555. Four multiplies: AAAAAAAA×3F800000, 55555555×3F800000, 3F800000×AAAAAAAA, 3F800000×55555555. Then an add of FFFFFFFF+FFFFFFFF. Then a conversion with A=B=00000002. Then absolute difference with A=00005555,B=0000AAAA and with A=0000AAAA,B=00005555.
- R5: For the add, multiply, conversion and absolute-difference vectors, each result half that differs from its expected half adds one fault. The expected word is the nonzero add operand, the pattern operand of a multiply, 40000000 for the conversion, and 00005555 for absolute difference. A result with both halves wrong adds two faults.
- R6: The subtract vector adds at most one fault. The fault is added when the OR of its two result halves is nonzero.
- R7: The sampled status must equal 0xE after each of the four adds and after the last multiply, and 0x2 after the invalid add. Each mismatch adds one fault. Status after other vectors is ignored.
- R8: The fault count saturates at its all-ones value instead of wrapping.
- R9: After the last vector's checks, the completion strobe is high for one cycle with the pass total on the fault count. In the next cycle the count is zero and the first vector starts again.
- R10: The result of the invalid add is never compared, so wrong data from it adds no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_wr | output | 1 | Operand write strobe |
| fp_wsel | output | 1 | Write target: 0 = B operand, 1 = A operand |
| fp_wdata | output | 16 | Operand half being written |
| fp_op | output | 3 | Operation code, nonzero only with the A-upper write |
| fp_unload | output | 1 | Result unload strobe |
| fp_unload_hi | output | 1 | Unload select: 1 = upper half, 0 = lower half |
| fp_rdata | input | 16 | Result half, valid one cycle after its unload strobe |
| fp_status | input | 4 | Datapath status flags |
| fault_count | output | CNT_W | Saturating fault count of the current pass |
| pass_done | output | 1 | One-cycle strobe at the end of each pass |

## Verification
The checker assumes the datapath answers each unload one cycle later. It also assumes the status port holds steady from the final operand write until it is sampled. The assertions themselves only observe the sequencer's own outputs, so they place no limits on the data values. The bench's datapath model always answers on that schedule and updates status only when the A-lower half arrives. It creates faults only by flipping one bit of a result half or of the status nibble, and it switches its fault pattern only at a pass boundary. This way every pass has one well-defined expected total. The count is kept 4 bits wide so that a pass with every fault injected drives it into saturation.

// File: rtl/fst_pkg.sv
// Shared types and the fixed diagnostic program of the self-test sequencer.
// Assumes 32-bit operands moved as two 16-bit halves.
package fst_pkg;

    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int OP_W    = 3;
    localparam int NIB_W   = 4;
    localparam int NUM_VEC = 13;
    localparam int VIDX_W  = $clog2(NUM_VEC);

    localparam logic [WORD_W-1:0] PAT_HI1 = 32'hAAAA_AAAA;
    localparam logic [WORD_W-1:0] PAT_LO1 = 32'h5555_5555;
    localparam logic [WORD_W-1:0] F_ONE   = 32'h3F80_0000;
    localparam logic [WORD_W-1:0] ALL_ONE = 32'hFFFF_FFFF;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_I2F  = 3'd4,
        OP_ABS  = 3'd5
    } fst_op_e;

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_SPLIT = 2'd1,
        CK_OR    = 2'd2
    } fst_ck_e;

    typedef enum logic [3:0] {
        S_WB_HI, S_WB_LO, S_WA_HI, S_WA_LO, S_WAIT,
        S_UHI, S_ULO, S_CAP, S_CK_HI, S_CK_LO, S_CK_ST, S_DONE
    } fst_state_e;

    typedef struct packed {
        fst_op_e           op;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        fst_ck_e           ck;
        logic [WORD_W-1:0] want;
        logic              st_en;
        logic [NIB_W-1:0]  st_want;
    } fst_vec_t;

    // Return one step of the program; order follows the test schedule.
    function automatic fst_vec_t fst_vector(input logic [VIDX_W-1:0] idx);
        fst_vec_t v;
        v = '{OP_NONE, '0, '0, CK_NONE, '0, 1'b0, '0};
        case (idx)
            4'd0:  v = '{OP_ADD, PAT_HI1, '0,      CK_SPLIT, PAT_HI1, 1'b1, 4'hE};
            4'd1:  v = '{OP_ADD, PAT_LO1, '0,      CK_SPLIT, PAT_LO1, 1'b1, 4'hE};
            4'd2:  v = '{OP_ADD, '0,      PAT_LO1, CK_SPLIT, PAT_LO1, 1'b1, 4'hE};
            4'd3:  v = '{OP_ADD, '0,      PAT_HI1, CK_SPLIT, PAT_HI1, 1'b1, 4'hE};
            4'd4:  v = '{OP_SUB, PAT_LO1, PAT_LO1, CK_OR,    '0,      1'b0, 4'h0};
            4'd5:  v = '{OP_MUL, PAT_HI1, F_ONE,   CK_SPLIT, PAT_HI1, 1'b0, 4'h0};
            4'd6:  v = '{OP_MUL, PAT_LO1, F_ONE,   CK_SPLIT, PAT_LO1, 1'b0, 4'h0};
            4'd7:  v = '{OP_MUL, F_ONE,   PAT_HI1, CK_SPLIT, PAT_HI1, 1'b0, 4'h0};
            4'd8:  v = '{OP_MUL, F_ONE,   PAT_LO1, CK_SPLIT, PAT_LO1, 1'b1, 4'hE};
            4'd9:  v = '{OP_ADD, ALL_ONE, ALL_ONE, CK_NONE,  '0,      1'b1, 4'h2};
            4'd10: v = '{OP_I2F, 32'h2,   32'h2,   CK_SPLIT, 32'h4000_0000, 1'b0, 4'h0};
            4'd11: v = '{OP_ABS, 32'h5555, 32'hAAAA, CK_SPLIT, 32'h5555, 1'b0, 4'h0};
            4'd12: v = '{OP_ABS, 32'hAAAA, 32'h5555, CK_SPLIT, 32'h5555, 1'b0, 4'h0};
            default: v = '{OP_NONE, '0, '0, CK_NONE, '0, 1'b0, '0};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fst_vec_rom.sv
// Program store: maps a step index to its operands, opcode and expectations.
// Assumes idx stays below NUM_VEC; other values yield an inert step.
module fst_vec_rom
    import fst_pkg::*;
(
    input  logic [VIDX_W-1:0] idx,
    output fst_vec_t          vec
);

    // Decode the current step from the computed program.
    always_comb vec = fst_vector(idx);

endmodule

// File: rtl/fst_seq.sv
// Bus sequencer: writes operands, waits, unloads the result, captures it
// with status, then walks three check phases per step and loops the program.
// Assumes the datapath presents each result half one cycle after its strobe.
module fst_seq
    import fst_pkg::*;
#(
    parameter int WAIT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fst_op_e           vec_op,
    input  logic [WORD_W-1:0] vec_a,
    input  logic [WORD_W-1:0] vec_b,
    input  logic [HALF_W-1:0] fp_rdata,
    input  logic [NIB_W-1:0]  fp_status,
    output logic              fp_wr,
    output logic              fp_wsel,
    output logic [HALF_W-1:0] fp_wdata,
    output logic [OP_W-1:0]   fp_op,
    output logic              fp_unload,
    output logic              fp_unload_hi,
    output logic [VIDX_W-1:0] vec_idx,
    output logic [WORD_W-1:0] res_word,
    output logic [NIB_W-1:0]  res_stat,
    output logic              ck_hi,
    output logic              ck_lo,
    output logic              ck_st,
    output logic              pass_done
);

    localparam int WAIT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYC - 1);
    localparam logic [VIDX_W-1:0] IDX_LAST  = VIDX_W'(NUM_VEC - 1);

    fst_state_e        state;
    logic [WAIT_W-1:0] wait_cnt;

    // Advance the program state, the idle counter and the step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_WB_HI;
            wait_cnt <= '0;
            vec_idx  <= '0;
        end else begin
            case (state)
                S_WB_HI: state <= S_WB_LO;
                S_WB_LO: state <= S_WA_HI;
                S_WA_HI: state <= S_WA_LO;
                S_WA_LO: begin
                    state    <= S_WAIT;
                    wait_cnt <= '0;
                end
                S_WAIT: begin
                    if (wait_cnt == WAIT_LAST) state <= S_UHI;
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                S_UHI:   state <= S_ULO;
                S_ULO:   state <= S_CAP;
                S_CAP:   state <= S_CK_HI;
                S_CK_HI: state <= S_CK_LO;
                S_CK_LO: state <= S_CK_ST;
                S_CK_ST: begin
                    if (vec_idx == IDX_LAST) begin
                        state <= S_DONE;
                    end else begin
                        vec_idx <= vec_idx + 1'b1;
                        state   <= S_WB_HI;
                    end
                end
                S_DONE: begin
                    vec_idx <= '0;
                    state   <= S_WB_HI;
                end
                default: state <= S_WB_HI;
            endcase
        end
    end

    // Capture the two result halves and the status once each is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_word <= '0;
            res_stat <= '0;
        end else begin
            if (state == S_ULO) res_word[WORD_W-1:HALF_W] <= fp_rdata;
            if (state == S_CAP) begin
                res_word[HALF_W-1:0] <= fp_rdata;
                res_stat             <= fp_status;
            end
        end
    end

    // Drive the operand bus from the current write phase.
    always_comb begin
        fp_wdata = '0;
        case (state)
            S_WB_HI: fp_wdata = vec_b[WORD_W-1:HALF_W];
            S_WB_LO: fp_wdata = vec_b[HALF_W-1:0];
            S_WA_HI: fp_wdata = vec_a[WORD_W-1:HALF_W];
            S_WA_LO: fp_wdata = vec_a[HALF_W-1:0];
            default: fp_wdata = '0;
        endcase
    end

    // Strobes and phase flags decoded from the state.
    always_comb begin
        fp_wr        = (state == S_WB_HI) || (state == S_WB_LO) ||
                       (state == S_WA_HI) || (state == S_WA_LO);
        fp_wsel      = (state == S_WA_HI) || (state == S_WA_LO);
        fp_op        = (state == S_WA_HI) ? vec_op : OP_NONE;
        fp_unload    = (state == S_UHI) || (state == S_ULO);
        fp_unload_hi = (state == S_UHI);
        ck_hi        = (state == S_CK_HI);
        ck_lo        = (state == S_CK_LO);
        ck_st        = (state == S_CK_ST);
        pass_done    = (state == S_DONE);
    end

endmodule

// File: rtl/fst_judge.sv
// Comparator: raises one fault pulse per failed check phase of a step.
// Assumes exactly one of ck_hi, ck_lo, ck_st is high at a time.
module fst_judge
    import fst_pkg::*;
(
    input  fst_ck_e           ck_kind,
    input  logic [WORD_W-1:0] want,
    input  logic              st_en,
    input  logic [NIB_W-1:0]  st_want,
    input  logic [WORD_W-1:0] res_word,
    input  logic [NIB_W-1:0]  res_stat,
    input  logic              ck_hi,
    input  logic              ck_lo,
    input  logic              ck_st,
    output logic              fault
);

    logic hi_bad, lo_bad, or_bad, st_bad;

    // Evaluate every comparison, then select by the active phase.
    always_comb begin
        hi_bad = res_word[WORD_W-1:HALF_W] != want[WORD_W-1:HALF_W];
        lo_bad = res_word[HALF_W-1:0] != want[HALF_W-1:0];
        or_bad = (res_word[WORD_W-1:HALF_W] | res_word[HALF_W-1:0]) != '0;
        st_bad = st_en && (res_stat != st_want);
        fault  = (ck_hi && (((ck_kind == CK_SPLIT) && hi_bad) ||
                            ((ck_kind == CK_OR) && or_bad))) ||
                 (ck_lo && (ck_kind == CK_SPLIT) && lo_bad) ||
                 (ck_st && st_bad);
    end

endmodule

// File: rtl/fst_fault_cnt.sv
// Saturating fault counter, cleared at the start of every pass.
// Assumes clr and inc are never high together.
module fst_fault_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] bumped;

    // Next value; a wrap to zero means the count was already full.
    always_comb bumped = count + 1'b1;

    // Hold, clear or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (clr)                    count <= '0;
        else if (inc && (bumped != '0))  count <= bumped;
    end

endmodule

// File: rtl/fpu_selftest.sv
// Top of the floating-point self-test sequencer: program store, bus
// sequencer, comparator and saturating fault counter.
// Assumes an external datapath on the 16-bit bus answers every unload.
module fpu_selftest
    import fst_pkg::*;
#(
    parameter int WAIT_CYC = 5,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fp_wr,
    output logic              fp_wsel,
    output logic [15:0]       fp_wdata,
    output logic [2:0]        fp_op,
    output logic              fp_unload,
    output logic              fp_unload_hi,
    input  logic [15:0]       fp_rdata,
    input  logic [3:0]        fp_status,
    output logic [CNT_W-1:0]  fault_count,
    output logic              pass_done
);

    logic [VIDX_W-1:0] vec_idx;
    fst_vec_t          vec;
    logic [WORD_W-1:0] res_word;
    logic [NIB_W-1:0]  res_stat;
    logic              ck_hi, ck_lo, ck_st, fault;

    fst_vec_rom u_rom (
        .idx (vec_idx),
        .vec (vec)
    );

    fst_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_op       (vec.op),
        .vec_a        (vec.a),
        .vec_b        (vec.b),
        .fp_rdata     (fp_rdata),
        .fp_status    (fp_status),
        .fp_wr        (fp_wr),
        .fp_wsel      (fp_wsel),
        .fp_wdata     (fp_wdata),
        .fp_op        (fp_op),
        .fp_unload    (fp_unload),
        .fp_unload_hi (fp_unload_hi),
        .vec_idx      (vec_idx),
        .res_word     (res_word),
        .res_stat     (res_stat),
        .ck_hi        (ck_hi),
        .ck_lo        (ck_lo),
        .ck_st        (ck_st),
        .pass_done    (pass_done)
    );

    fst_judge u_judge (
        .ck_kind  (vec.ck),
        .want     (vec.want),
        .st_en    (vec.st_en),
        .st_want  (vec.st_want),
        .res_word (res_word),
        .res_stat (res_stat),
        .ck_hi    (ck_hi),
        .ck_lo    (ck_lo),
        .ck_st    (ck_st),
        .fault    (fault)
    );

    fst_fault_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pass_done),
        .inc   (fault),
        .count (fault_count)
    );

endmodule

// File: rtl/fst_checker.sv
// Protocol and counter checks for the self-test sequencer, bound to the top.
// Assumes nothing about data values; observes only the sequencer's outputs.
module fst_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fp_wr,
    input logic             fp_wsel,
    input logic [2:0]       fp_op,
    input logic             fp_unload,
    input logic             fp_unload_hi,
    input logic [CNT_W-1:0] fault_count,
    input logic             pass_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_OP_ON_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_op != 3'd0) |-> (fp_wr && fp_wsel)); // R2
    AST_OP_THEN_A_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_op != 3'd0) |=> (fp_wr && fp_wsel && fp_op == 3'd0)); // R2
    AST_BUS_ONE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fp_wr && fp_unload)); // R3
    AST_UNLOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_unload && fp_unload_hi) |=> (fp_unload && !fp_unload_hi)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done); // R9
    AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> (fault_count == '0)); // R9
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_done |=> (fault_count == $past(fault_count) ||
                        fault_count == CNT_W'($past(fault_count) + 1'b1))); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count == CNT_MAX && !pass_done) |=> (fault_count == CNT_MAX)); // R8

endmodule

bind fpu_selftest fst_checker #(.CNT_W(CNT_W)) u_fst_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fp_wr        (fp_wr),
    .fp_wsel      (fp_wsel),
    .fp_op        (fp_op),
    .fp_unload    (fp_unload),
    .fp_unload_hi (fp_unload_hi),
    .fault_count  (fault_count),
    .pass_done    (pass_done)
);

// File: tb/tb_fpu_selftest.sv
`timescale 1ns/1ps
module tb_fpu_selftest;

    localparam int WAIT_CYC = 5;
    localparam int CNT_W    = 4;
    localparam int NV       = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fp_wr, fp_wsel, fp_unload, fp_unload_hi, pass_done;
    logic [15:0]       fp_wdata;
    logic [2:0]        fp_op;
    logic [15:0]       fp_rdata = '0;
    logic [3:0]        fp_status = 4'hE;
    logic [CNT_W-1:0]  fault_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fpu_selftest #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .fp_wr(fp_wr), .fp_wsel(fp_wsel),
        .fp_wdata(fp_wdata), .fp_op(fp_op), .fp_unload(fp_unload),
        .fp_unload_hi(fp_unload_hi), .fp_rdata(fp_rdata), .fp_status(fp_status),
        .fault_count(fault_count), .pass_done(pass_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Program of R4, written from the requirement.
    task automatic want_vec(input int v, output logic [2:0] op, output logic [31:0] a, output logic [31:0] b);
        case (v)
            0:  begin op = 3'd1; a = 32'hAAAAAAAA; b = 32'h0; end
            1:  begin op = 3'd1; a = 32'h55555555; b = 32'h0; end
            2:  begin op = 3'd1; a = 32'h0; b = 32'h55555555; end
            3:  begin op = 3'd1; a = 32'h0; b = 32'hAAAAAAAA; end
            4:  begin op = 3'd2; a = 32'h55555555; b = 32'h55555555; end
            5:  begin op = 3'd3; a = 32'hAAAAAAAA; b = 32'h3F800000; end
            6:  begin op = 3'd3; a = 32'h55555555; b = 32'h3F800000; end
            7:  begin op = 3'd3; a = 32'h3F800000; b = 32'hAAAAAAAA; end
            8:  begin op = 3'd3; a = 32'h3F800000; b = 32'h55555555; end
            9:  begin op = 3'd1; a = 32'hFFFFFFFF; b = 32'hFFFFFFFF; end
            10: begin op = 3'd4; a = 32'h2; b = 32'h2; end
            11: begin op = 3'd5; a = 32'h5555; b = 32'hAAAA; end
            default: begin op = 3'd5; a = 32'hAAAA; b = 32'h5555; end
        endcase
    endtask

    function automatic logic [31:0] int_to_float(input logic [23:0] x);
        int p = -1;
        logic [31:0] m;
        for (int i = 0; i < 24; i++) if (x[i]) p = i;
        if (p < 0) return 32'h0;
        m = (32'(x) << (23 - p)) & 32'h007FFFFF;
        return {1'b0, 8'(127 + p), m[22:0]};
    endfunction

    // Behavioural datapath used as the bus partner.
    function automatic logic [31:0] fpu_model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd1: return a + b;
            3'd2: return a - b;
            3'd3: return (b == 32'h3F800000) ? a : ((a == 32'h3F800000) ? b : 32'h0);
            3'd4: return int_to_float(a[23:0]);
            3'd5: return (a > b) ? a - b : b - a;
            default: return 32'h0;
        endcase
    endfunction

    // Expected pass total from R5..R8 and R10.
    function automatic int expect_total(input logic [NV-1:0] h, input logic [NV-1:0] l, input logic [NV-1:0] s);
        int t = 0;
        for (int v = 0; v < NV; v++) begin
            if (v == 4) t += int'(h[v] | l[v]);
            else if (v != 9) t += int'(h[v]) + int'(l[v]);
            if (v <= 3 || v == 8 || v == 9) t += int'(s[v]);
        end
        if (t > (1 << CNT_W) - 1) t = (1 << CNT_W) - 1;
        return t;
    endfunction

    logic [NV-1:0] m_hi = '0, m_lo = '0, m_st = '0;

    // Model state, all updated at the falling edge.
    logic [31:0] a_w, b_w, res;
    logic [2:0]  op_seen;
    logic [15:0] pend;
    bit          a_ph, b_ph, in_gap, hi_prev;
    int          vcount, gap, b_n;

    always @(negedge clk) begin
        logic [2:0]  e_op;
        logic [31:0] e_a, e_b;
        if (!rst_n) begin
            a_ph = 0; b_ph = 0; in_gap = 0; hi_prev = 0;
            vcount = 0; gap = 0; b_n = 0; op_seen = 0; pend = 0;
            fp_rdata = 0;
        end else begin
            fp_rdata = pend;
            pend = 0;
            if (fp_op != 3'd0) begin
                chk(fp_wr && fp_wsel && !a_ph, "R2 opcode only on A upper write", {29'b0, fp_op}, 32'h0);
                op_seen = fp_op;
            end
            if (fp_wr) begin
                if (!fp_wsel) begin
                    if (!b_ph) b_w[31:16] = fp_wdata; else b_w[15:0] = fp_wdata;
                    b_ph = !b_ph;
                    b_n++;
                end else begin
                    if (!a_ph) a_w[31:16] = fp_wdata;
                    else begin
                        a_w[15:0] = fp_wdata;
                        want_vec(vcount, e_op, e_a, e_b);
                        chk(b_n == 2, "R2 two B writes before A", 32'(b_n), 32'd2);
                        chk(op_seen == e_op, "R4 opcode", {29'b0, op_seen}, {29'b0, e_op});
                        chk(a_w == e_a, "R4 A operand", a_w, e_a);
                        chk(b_w == e_b, "R4 B operand", b_w, e_b);
                        res = fpu_model(op_seen, a_w, b_w) ^ {15'b0, m_hi[vcount], 15'b0, m_lo[vcount]};
                        fp_status = ((a_w[30:23] == 8'hFF || b_w[30:23] == 8'hFF) ? 4'h2 : 4'hE)
                                    ^ {3'b0, m_st[vcount]};
                        vcount = (vcount == NV - 1) ? 0 : vcount + 1;
                        b_n = 0; op_seen = 0; in_gap = 1; gap = 0;
                    end
                    a_ph = !a_ph;
                end
            end
            if (fp_unload) begin
                if (fp_unload_hi) begin
                    chk(in_gap && gap == WAIT_CYC, "R3 idle cycles before unload", 32'(gap), 32'(WAIT_CYC));
                    in_gap = 0; hi_prev = 1;
                    pend = res[31:16];
                end else begin
                    chk(hi_prev, "R3 lower unload right after upper", 32'(hi_prev), 32'd1);
                    hi_prev = 0;
                    pend = res[15:0];
                end
            end else begin
                if (hi_prev) chk(0, "R3 lower unload missing", 32'd0, 32'd1);
                hi_prev = 0;
                if (!fp_wr && in_gap) gap++;
            end
        end
    end

    // Scoreboard of pass totals.
    int    exp_q[$];
    string tag_q[$];
    bit    post_done = 0;

    always @(negedge clk) begin
        int    e;
        string t;
        if (rst_n) begin
            if (post_done) begin
                chk(fault_count == '0 && !pass_done, "R9 count cleared, strobe one cycle",
                    {27'b0, pass_done, fault_count}, 32'h0);
                post_done = 0;
            end
            if (pass_done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected pass end", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(fault_count == CNT_W'(e), t, 32'(fault_count), 32'(e));
                end
                post_done = 1;
            end
        end
    end

    // Driver: set the injection pattern for one pass and queue its total.
    task automatic run_pass(input logic [NV-1:0] h, input logic [NV-1:0] l, input logic [NV-1:0] s, input string tag);
        m_hi = h; m_lo = l; m_st = s;
        exp_q.push_back(expect_total(h, l, s));
        tag_q.push_back(tag);
        @(negedge clk);
        while (!pass_done) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(fault_count == '0 && !pass_done && !fp_unload && fp_op == 3'd0,
            "R1 state during reset", {23'b0, fp_unload, pass_done, fp_op, fault_count}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_count == '0 && !pass_done && !fp_unload, "R1 state after reset",
            {26'b0, fp_unload, pass_done, fault_count}, 32'h0);
        run_pass('0, '0, '0, "R5 clean pass total");
        run_pass(13'h0001, '0, '0, "R5 upper half wrong once");
        run_pass(13'h0400, 13'h0400, '0, "R5 both halves of conversion wrong");
        run_pass(13'h0010, 13'h0010, '0, "R6 subtract counts once");
        run_pass(13'h0200, 13'h0200, '0, "R10 invalid add result ignored");
        run_pass('0, '0, 13'h00E0, "R7 status of early multiplies ignored");
        run_pass('0, '0, 13'h0300, "R7 status after multiply and invalid add");
        run_pass('1, '1, '1, "R8 saturated total");
        run_pass('0, '0, '0, "R9 fresh pass after saturation");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule